// File: doc/BRIEF.md
# Register File with Shadowed Special Registers

This block is the register store of a small processor core: 512 words of 32 bits, with three read ports (instruction fetch, source operand, destination operand) and one write port. The low 496 addresses are ordinary working registers. The top 16 addresses form a special window.

Six addresses in the special window front hardware values that software cannot change: a start parameter, a free-running count, two input-pin banks and two phase accumulators. Each of these addresses also has a hidden stored word, called the shadow. Which word a read returns depends on the read port. A source-operand read returns the live hardware value. A fetch or a destination-operand read returns the shadow. A write always goes to the shadow. As a result, code can be placed in these addresses and run as written, and a read-modify-write loop counter can live there, while a plain source read still sees the hardware.

Four writable control words (two output-level banks and two direction banks) drive output ports straight from storage, so a write changes the pin configuration from the next cycle on. All reads are combinational. Writes land on the rising clock edge.

Top module: `rfs_regfile`

## Requirements
- R1: A write with `wr_en_i` high to an address in 0x000–0x1EF is returned, from the next clock edge on, by all three read ports at that address.
- R2: Reads are combinational. During the cycle a write to an address is presented, a read of that address returns the old value, and it returns the new value after the clock edge.
- R3: A source-port read of a live address returns the matching hardware word from `live_i`, where slot k occupies bits [32k+31:32k]: 0x1F0→slot 0, 0x1F1→slot 1, 0x1F2→slot 2, 0x1F3→slot 3, 0x1FC→slot 4, 0x1FD→slot 5.
- R4: A fetch-port read of a live address returns that address's shadow word, not the hardware word.
- R5: A destination-port read of a live address returns that address's shadow word.
- R6: A write to a live address stores into its shadow word only. Source reads of that address keep returning the hardware word.
- R7: After the write edge, writes to 0x1F4, 0x1F5, 0x1F6 and 0x1F7 appear on `lvl_lo_o`, `lvl_hi_o`, `oe_lo_o` and `oe_hi_o` respectively.
- R8: Every special address that is not live (0x1F4–0x1FB, 0x1FE, 0x1FF) returns its stored word on all three read ports.
- R9: While `rst_ni` is low, all 16 special words clear to zero. This includes the shadows and the four control outputs. The working registers are not reset.
- R10: A cycle with `wr_en_i` low changes no stored word and no control output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes land on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the special words |
| fetch_addr_i | input | 9 | Instruction fetch address |
| fetch_data_o | output | 32 | Fetch read data (shadow view) |
| src_addr_i | input | 9 | Source operand address |
| src_data_o | output | 32 | Source read data (live view on live addresses) |
| dst_addr_i | input | 9 | Destination operand address |
| dst_data_o | output | 32 | Destination read data (shadow view) |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 9 | Write address |
| wr_data_i | input | 32 | Write data |
| live_i | input | 192 | Six hardware words, slot k at bits [32k+31:32k] |
| lvl_lo_o | output | 32 | Output-level bank, low pins (word 0x1F4) |
| lvl_hi_o | output | 32 | Output-level bank, high pins (word 0x1F5) |
| oe_lo_o | output | 32 | Direction bank, low pins (word 0x1F6) |
| oe_hi_o | output | 32 | Direction bank, high pins (word 0x1F7) |

## Verification
The bench targets the split view of the live addresses. It writes a shadow and then reads the same address on all three ports in one cycle while the hardware word holds a different value. A design that muxes the live word on every port fails the fetch and destination checks. A design that lets a write overwrite the hardware view fails the source check. It also presents a write and a same-address read in one cycle, which catches a write-through bypass, and it checks that the control outputs follow their words and that a disabled write leaves them alone. Random traffic crosses the boundary between the working registers and the special window, where an off-by-one decode sends a word to the wrong store.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

   typedef enum logic [1:0] {
      PORT_FETCH = 2'd0,
      PORT_SRC   = 2'd1,
      PORT_DST   = 2'd2
   } port_kind_e;

   localparam int N_PORTS = 3;

   // number of set bits in the low n bits of a mask
   function automatic int ones_below(logic [31:0] mask, int n);
      int c;
      c = 0;
      for (int i = 0; i < 32; i++)
         if (i < n && mask[i]) c++;
      return c;
   endfunction

endpackage

// File: rtl/rfs_gp_bank.sv
module rfs_gp_bank #(
   parameter int DW     = 32,
   parameter int AW     = 9,
   parameter int GP_CNT = 496,
   parameter int NRD    = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic [NRD*AW-1:0] raddr_i,
   output logic [NRD*DW-1:0] rdata_o
);

   logic [DW-1:0] mem [GP_CNT];
   logic          in_range;

   assign in_range = (waddr_i < AW'(GP_CNT));

   always_ff @(posedge clk_i) begin
      if (we_i && in_range) mem[waddr_i] <= wdata_i;
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      logic [AW-1:0] ra;
      assign ra = raddr_i[g*AW +: AW];
      assign rdata_o[g*DW +: DW] = (ra < AW'(GP_CNT)) ? mem[ra] : '0;
   end

   // R1: a working-register write is held in storage after the edge
   p_gp_store_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && in_range) |=> (mem[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/rfs_spr_bank.sv
module rfs_spr_bank #(
   parameter int DW      = 32,
   parameter int SPR_CNT = 16,
   parameter int SW      = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  we_i,
   input  logic [SW-1:0]         widx_i,
   input  logic [DW-1:0]         wdata_i,
   output logic [SPR_CNT*DW-1:0] words_o
);

   logic [DW-1:0] word_q [SPR_CNT];

   for (genvar g = 0; g < SPR_CNT; g++) begin : g_word
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                         word_q[g] <= '0;
         else if (we_i && widx_i == SW'(g))   word_q[g] <= wdata_i;
      end
      assign words_o[g*DW +: DW] = word_q[g];
   end

   // R6: a special write lands in the stored word it addresses
   p_spr_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (words_o[$past(widx_i)*DW +: DW] == $past(wdata_i)));

   // R10: no write, no change
   p_spr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(words_o));

endmodule

// File: rtl/rfs_read_ports.sv
module rfs_read_ports
   import rfs_pkg::*;
#(
   parameter int          DW        = 32,
   parameter int          AW        = 9,
   parameter int          SPR_CNT   = 16,
   parameter int          SW        = 4,
   parameter logic [31:0] LIVE_MASK = 32'h0000_300F,
   parameter int          N_LIVE    = 6
) (
   input  logic [N_PORTS*AW-1:0] addr_i,
   input  logic [N_PORTS*DW-1:0] gp_data_i,
   input  logic [SPR_CNT*DW-1:0] spr_words_i,
   input  logic [N_LIVE*DW-1:0]  live_i,
   output logic [N_PORTS*DW-1:0] data_o
);

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      localparam bit SHOW_LIVE = (p == int'(PORT_SRC));
      logic [AW-1:0] a;
      logic          is_spr;
      logic [SW-1:0] ofs;
      logic [DW-1:0] cand [SPR_CNT];

      assign a      = addr_i[p*AW +: AW];
      assign is_spr = &a[AW-1:SW];
      assign ofs    = a[SW-1:0];

      for (genvar s = 0; s < SPR_CNT; s++) begin : g_cand
         if (SHOW_LIVE && LIVE_MASK[s]) begin : g_live
            localparam int SLOT = ones_below(LIVE_MASK, s);
            assign cand[s] = live_i[SLOT*DW +: DW];
         end else begin : g_store
            assign cand[s] = spr_words_i[s*DW +: DW];
         end
      end

      assign data_o[p*DW +: DW] = is_spr ? cand[ofs] : gp_data_i[p*DW +: DW];
   end

endmodule

// File: rtl/rfs_regfile.sv
module rfs_regfile
   import rfs_pkg::*;
#(
   parameter int          DW         = 32,
   parameter int          AW         = 9,
   parameter int          SPR_CNT    = 16,
   parameter logic [31:0] LIVE_MASK  = 32'h0000_300F,
   parameter int          OFS_LVL_LO = 4,
   parameter int          OFS_LVL_HI = 5,
   parameter int          OFS_OE_LO  = 6,
   parameter int          OFS_OE_HI  = 7,
   localparam int         N_LIVE     = ones_below(LIVE_MASK, SPR_CNT)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [AW-1:0]        fetch_addr_i,
   output logic [DW-1:0]        fetch_data_o,
   input  logic [AW-1:0]        src_addr_i,
   output logic [DW-1:0]        src_data_o,
   input  logic [AW-1:0]        dst_addr_i,
   output logic [DW-1:0]        dst_data_o,
   input  logic                 wr_en_i,
   input  logic [AW-1:0]        wr_addr_i,
   input  logic [DW-1:0]        wr_data_i,
   input  logic [N_LIVE*DW-1:0] live_i,
   output logic [DW-1:0]        lvl_lo_o,
   output logic [DW-1:0]        lvl_hi_o,
   output logic [DW-1:0]        oe_lo_o,
   output logic [DW-1:0]        oe_hi_o
);

   localparam int DEPTH  = 1 << AW;
   localparam int GP_CNT = DEPTH - SPR_CNT;
   localparam int SW     = $clog2(SPR_CNT);

   // elaboration-time parameter checks
   if (SPR_CNT < 2 || SPR_CNT > 32 || (1 << SW) != SPR_CNT) begin : g_bad_cnt
      $error("SPR_CNT must be a power of two between 2 and 32");
   end
   if (SPR_CNT >= DEPTH) begin : g_bad_depth
      $error("special window must be smaller than the address space");
   end
   if (N_LIVE < 1) begin : g_bad_live
      $error("LIVE_MASK must select at least one address");
   end
   if (LIVE_MASK[OFS_LVL_LO] || LIVE_MASK[OFS_LVL_HI] ||
       LIVE_MASK[OFS_OE_LO]  || LIVE_MASK[OFS_OE_HI]) begin : g_bad_ctrl
      $error("control words must not be live addresses");
   end

   logic                    spr_we;
   logic [SPR_CNT*DW-1:0]   spr_words;
   logic [N_PORTS*AW-1:0]   rd_addr;
   logic [N_PORTS*DW-1:0]   gp_data;
   logic [N_PORTS*DW-1:0]   rd_data;

   assign spr_we  = wr_en_i & (&wr_addr_i[AW-1:SW]);
   assign rd_addr = {dst_addr_i, src_addr_i, fetch_addr_i};

   rfs_gp_bank #(.DW(DW), .AW(AW), .GP_CNT(GP_CNT), .NRD(N_PORTS)) u_gp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i),
      .waddr_i (wr_addr_i),
      .wdata_i (wr_data_i),
      .raddr_i (rd_addr),
      .rdata_o (gp_data)
   );

   rfs_spr_bank #(.DW(DW), .SPR_CNT(SPR_CNT), .SW(SW)) u_spr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (spr_we),
      .widx_i  (wr_addr_i[SW-1:0]),
      .wdata_i (wr_data_i),
      .words_o (spr_words)
   );

   rfs_read_ports #(
      .DW(DW), .AW(AW), .SPR_CNT(SPR_CNT), .SW(SW),
      .LIVE_MASK(LIVE_MASK), .N_LIVE(N_LIVE)
   ) u_rd (
      .addr_i      (rd_addr),
      .gp_data_i   (gp_data),
      .spr_words_i (spr_words),
      .live_i      (live_i),
      .data_o      (rd_data)
   );

   assign fetch_data_o = rd_data[int'(PORT_FETCH)*DW +: DW];
   assign src_data_o   = rd_data[int'(PORT_SRC)*DW +: DW];
   assign dst_data_o   = rd_data[int'(PORT_DST)*DW +: DW];

   assign lvl_lo_o = spr_words[OFS_LVL_LO*DW +: DW];
   assign lvl_hi_o = spr_words[OFS_LVL_HI*DW +: DW];
   assign oe_lo_o  = spr_words[OFS_OE_LO*DW +: DW];
   assign oe_hi_o  = spr_words[OFS_OE_HI*DW +: DW];

   localparam logic [AW-1:0] A_OE_LO  = AW'(GP_CNT + OFS_OE_LO);
   localparam logic [AW-1:0] A_LVL_LO = AW'(GP_CNT + OFS_LVL_LO);

   // R7: direction word drives its output from the cycle after the write
   p_oe_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == A_OE_LO) |=> (oe_lo_o == $past(wr_data_i)));

   // R7: output-level word likewise
   p_lvl_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == A_LVL_LO) |=> (lvl_lo_o == $past(wr_data_i)));

   // R9: reset leaves every control output at zero
   p_reset_clear_r9: assert property (@(posedge clk_i)
      !rst_ni |=> (lvl_lo_o == '0 && lvl_hi_o == '0 && oe_lo_o == '0 && oe_hi_o == '0));

endmodule

// File: tb/sim_rfs_regfile.sv
module sim_rfs_regfile;
   localparam int TCLK = 10;
   localparam int DW = 32, AW = 9, NS = 16, GPN = 496, NL = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(TCLK/2) clk = ~clk;

   logic [AW-1:0]    fetch_addr = '0, src_addr = '0, dst_addr = '0, wr_addr = '0;
   logic [DW-1:0]    fetch_data, src_data, dst_data, wr_data = '0;
   logic             wr_en = 1'b0;
   logic [NL*DW-1:0] live = '0;
   logic [DW-1:0]    lvl_lo, lvl_hi, oe_lo, oe_hi;

   rfs_regfile u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .fetch_addr_i(fetch_addr), .fetch_data_o(fetch_data),
      .src_addr_i(src_addr), .src_data_o(src_data),
      .dst_addr_i(dst_addr), .dst_data_o(dst_data),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .live_i(live),
      .lvl_lo_o(lvl_lo), .lvl_hi_o(lvl_hi), .oe_lo_o(oe_lo), .oe_hi_o(oe_hi)
   );

   logic [DW-1:0] m_gp [GPN];
   bit            m_ok [GPN];
   logic [DW-1:0] m_sp [NS];
   int errs = 0, chks = 0;
   bit done = 1'b0;

   function automatic int slot_of(int ofs);
      case (ofs)
         0: return 0;  1: return 1;  2: return 2;  3: return 3;
         12: return 4; 13: return 5;
         default: return -1;
      endcase
   endfunction

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      chks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // kind: 0 fetch, 1 source, 2 destination
   task automatic chk_port(int kind, logic [AW-1:0] a, logic [DW-1:0] act);
      int ofs, s;
      if (a < GPN) begin
         if (m_ok[a]) chk("R1 working register read", act, m_gp[a]);
      end else begin
         ofs = int'(a) - GPN;
         s = slot_of(ofs);
         if (s >= 0) begin
            if (kind == 1)      chk("R3 source sees live word", act, live[s*DW +: DW]);
            else if (kind == 0) chk("R4 fetch sees shadow", act, m_sp[ofs]);
            else                chk("R5 destination sees shadow", act, m_sp[ofs]);
         end else begin
            chk("R8 plain special word", act, m_sp[ofs]);
         end
      end
   endtask

   task automatic chk_outs(string tag);
      chk(tag, lvl_lo, m_sp[4]);
      chk(tag, lvl_hi, m_sp[5]);
      chk(tag, oe_lo,  m_sp[6]);
      chk(tag, oe_hi,  m_sp[7]);
   endtask

   task automatic step(bit we, logic [AW-1:0] wa, logic [DW-1:0] wd,
                       logic [AW-1:0] fa, logic [AW-1:0] sa, logic [AW-1:0] da);
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd;
      fetch_addr = fa; src_addr = sa; dst_addr = da;
      for (int k = 0; k < NL; k++) live[k*DW +: DW] = $urandom;
      #1;
      chk_port(0, fa, fetch_data);
      chk_port(1, sa, src_data);
      chk_port(2, da, dst_data);
      chk_outs(we ? "R7 control outputs" : "R10 control outputs unchanged");
      @(posedge clk);
      if (we) begin
         if (wa < GPN) begin m_gp[wa] = wd; m_ok[wa] = 1'b1; end
         else m_sp[int'(wa) - GPN] = wd;
      end
   endtask

   function automatic logic [AW-1:0] rnd_addr();
      if ($urandom % 2) return AW'(GPN + ($urandom % NS));
      return AW'(GPN - 8 + ($urandom % 16)) - AW'(($urandom % 2) * 64);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, chks);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      errs++; chks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < GPN; i++) m_ok[i] = 1'b0;
      for (int i = 0; i < NS; i++) m_sp[i] = '0;

      // R9: reset state, with a write presented during reset
      wr_en = 1'b1; wr_addr = 9'h1F6; wr_data = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_outs("R9 outputs in reset");
      fetch_addr = 9'h1F2; dst_addr = 9'h1F6; #1;
      chk("R9 shadow cleared", fetch_data, '0);
      chk("R9 control word cleared", dst_data, '0);
      wr_en = 1'b0;
      rst_n = 1'b1;

      // R6 / R3 / R4 / R5: shadow write on an input-pin address
      step(1'b1, 9'h1F2, 32'hDEAD_BEEF, 9'h1F2, 9'h1F2, 9'h1F2);
      @(negedge clk);
      wr_en = 1'b0;
      live[2*DW +: DW] = 32'h0000_1234;
      fetch_addr = 9'h1F2; src_addr = 9'h1F2; dst_addr = 9'h1F2; #1;
      chk("R6 source unaffected by write", src_data, 32'h0000_1234);
      chk("R4 fetch returns written shadow", fetch_data, 32'hDEAD_BEEF);
      chk("R5 destination returns written shadow", dst_data, 32'hDEAD_BEEF);
      live[2*DW +: DW] = 32'hCAFE_0001; #1;
      chk("R3 source follows live change", src_data, 32'hCAFE_0001);
      chk("R4 fetch ignores live change", fetch_data, 32'hDEAD_BEEF);

      // R3: accumulator B lives in slot 5 at 0x1FD
      src_addr = 9'h1FD; live[5*DW +: DW] = 32'h5A5A_0005; #1;
      chk("R3 slot 5 at 0x1FD", src_data, 32'h5A5A_0005);

      // R2: same-cycle write and read of one working register
      step(1'b1, 9'h020, 32'h1111_0000, 9'h000, 9'h000, 9'h000);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 9'h020; wr_data = 32'h2222_0000;
      fetch_addr = 9'h020; src_addr = 9'h020; dst_addr = 9'h020; #1;
      chk("R2 read during write is old", fetch_data, 32'h1111_0000);
      chk("R2 source during write is old", src_data, 32'h1111_0000);
      @(posedge clk);
      m_gp[32] = 32'h2222_0000;
      #1;
      chk("R2 read after edge is new", dst_data, 32'h2222_0000);

      // R7: direction word drives output after the edge
      step(1'b1, 9'h1F7, 32'h0000_00F0, 9'h1F7, 9'h1F7, 9'h1F7);
      #1 chk("R7 high direction output", oe_hi, 32'h0000_00F0);

      // R10: disabled write with data on the bus
      step(1'b0, 9'h1F7, 32'hFFFF_FFFF, 9'h1F7, 9'h1F7, 9'h1F7);
      #1 chk("R10 disabled write ignored", oe_hi, 32'h0000_00F0);

      // R1 boundary: last working register and first special word
      step(1'b1, 9'h1EF, 32'h0BAD_F00D, 9'h1EF, 9'h1EF, 9'h1EF);
      step(1'b1, 9'h1F0, 32'h0123_4567, 9'h1EF, 9'h1F0, 9'h1F0);
      step(1'b0, 9'h000, 32'h0, 9'h1F0, 9'h1EF, 9'h1F0);

      // random traffic
      for (int n = 0; n < 3000; n++)
         step(($urandom % 4) != 0, rnd_addr(), $urandom, rnd_addr(), rnd_addr(), rnd_addr());

      finish_run();
   end
endmodule